// File: doc/BRIEF.md
# Power-Down Mode Sequencer

This block keeps track of which operating mode a small microcontroller is in and steps it between two full-speed active modes (high and medium speed), a subclock active mode, a subclock sleep mode, a watch mode and a deep standby mode. A one-cycle sleep request from the CPU is read together with a handful of mode-select inputs that come from the system and timer control registers. The request moves the chip into one of the low-power modes. An enabled, unmasked interrupt from timer A or from external interrupt line 0 brings it back. When the way back leads into an active mode, the block first waits out a programmable oscillator settling time.

The outputs are a clock enable for each domain (CPU, general peripherals, timer A), a hold signal that keeps registers, RAM and I/O pins retained, a one-cycle wake-up exception request, and a three-bit mode code. The reset input may arrive in any mode. It always leads through the settling wait into high-speed active mode, and no exception request is raised.

Top module: `pdm_seq`

## Requirements
- R1: While `rst_n` is low, and for exactly 16 cycles after it rises (settle select 7, whatever `settleSel` holds), `modeCode` is 6 (settling). After that it becomes 0 (high-speed active) and `wakeExc` stays low. This applies whatever mode was current when reset arrived.
- R2: In mode 0 or 1, a sleep request with `deepStop`=1 moves to watch (code 4) if `watchKeep`=1 and to standby (code 5) if `watchKeep`=0. With `deepStop`=0 the request has no effect.
- R3: In subactive mode (code 2), a sleep request with `deepStop`=0, `lowPwrSel`=1 and `watchKeep`=1 moves to subsleep (code 3). With `deepStop`=1 and `watchKeep`=1 it moves to watch. Any other combination leaves the mode at 2.
- R4: In watch mode a wake event counts only when `intMask`=0 and the source's enable is 1. Otherwise the mode stays at 4.
- R5: A counted wake from watch goes to subactive (code 2) on the next edge if `lowPwrSel`=1. Otherwise it goes through settling to medium speed (code 1) if `midSpeedSel`=1, or to high speed (code 0) if `midSpeedSel`=0.
- R6: Settling lasts exactly N cycles in mode 6, where N is taken from `settleSel` at wake time: 0→8192, 1→16384, 2→32768, 3→65536, 4→131072, 5→2, 6→8, 7→16. During settling the CPU, peripheral and timer-A enables are all 0 and `stateHold` is 1.
- R7: `wakeExc` is high for exactly one cycle, the first cycle in the target mode after an interrupt wake. It never follows a reset.
- R8: Enables by mode code: 0, 1 and 2 give cpu=1, periph=1, timerA=1, hold=0. Codes 3 and 4 give cpu=0, periph=0, timerA=1, hold=1. Codes 5 and 6 give all enables 0 and hold=1.
- R9: In subsleep, an unmasked enabled interrupt from either source moves to subactive on the next edge with `wakeExc`. A masked one is ignored.
- R10: Standby wakes only on an unmasked enabled `extIrq`, then settles into code 1 or 0 according to `midSpeedSel` (`lowPwrSel` is not used). A timer-A interrupt leaves it in code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset pin |
| sleepReq | input | 1 | One-cycle sleep request from the CPU |
| deepStop | input | 1 | Selects the standby/watch path for a sleep request |
| lowPwrSel | input | 1 | Selects subclock operation (subactive target) |
| midSpeedSel | input | 1 | Selects medium speed for an active target |
| watchKeep | input | 1 | Keeps timer A running in low power (watch/subsleep) |
| settleSel | input | 3 | Settling time select |
| intMask | input | 1 | Global interrupt mask |
| tmrAIrq | input | 1 | Timer A interrupt request |
| tmrAIrqEn | input | 1 | Timer A interrupt enable |
| extIrq | input | 1 | External interrupt 0 request |
| extIrqEn | input | 1 | External interrupt 0 enable |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| timerAClkEn | output | 1 | Timer A clock enable |
| stateHold | output | 1 | Register/RAM retain and I/O hold |
| wakeExc | output | 1 | Wake-up exception request pulse |
| modeCode | output | 3 | Current mode code |

## Verification
The mode register drives every output through a fixed decode. A wrong state therefore shows up on `modeCode` and on the clock enables in the cycle after the faulty edge, and the bench model compares both on every cycle. A settling counter that is off by even one cycle moves the exit out of mode 6 by one clock. A missing or repeated exception request shows on `wakeExc` in the exit cycle or the one after it. Gating errors, where a masked interrupt wakes the chip or an enabled one fails to, change the mode code one cycle after the interrupt pulse.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  typedef enum logic [2:0] {
    M_HIGH   = 3'd0,
    M_MED    = 3'd1,
    M_SUB    = 3'd2,
    M_SUBSLP = 3'd3,
    M_WATCH  = 3'd4,
    M_STBY   = 3'd5,
    M_SETTLE = 3'd6
  } pdm_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;     // restart the settling counter
    logic latchWake;  // capture settle select and active target
  } pdm_strobe_t;

endpackage

// File: rtl/pdm_dp.sv
module pdm_dp
  import pdm_pkg::*;
#(
  parameter int       LONG_LOG2 = 13,
  parameter logic [2:0] RST_SEL = 3'd7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  pdm_strobe_t stb,
  input  logic [2:0]  settleSel,
  input  logic        midSpeedSel,
  output pdm_mode_e   tgtMode,
  output logic        settleDone
);

  localparam int CNT_W = LONG_LOG2 + 5;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [2:0]       selQ;

  function automatic logic [CNT_W-1:0] limitOf(input logic [2:0] s);
    logic [CNT_W-1:0] v;
    case (s)
      3'd5:    v = CNT_W'(2);
      3'd6:    v = CNT_W'(8);
      3'd7:    v = CNT_W'(16);
      default: v = CNT_W'(1) << (LONG_LOG2 + 32'(s));
    endcase
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selQ    <= RST_SEL;
      tgtMode <= M_HIGH;
    end else if (stb.latchWake) begin
      selQ    <= settleSel;
      tgtMode <= midSpeedSel ? M_MED : M_HIGH;
    end
  end

  // free-running counter, restarted on entry to the wait
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (stb.clrCnt) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign lim        = limitOf(selQ);
  assign settleDone = (cnt == lim - 1'b1);

endmodule

// File: rtl/pdm_ctrl.sv
module pdm_ctrl
  import pdm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleepReq,
  input  logic        deepStop,
  input  logic        lowPwrSel,
  input  logic        watchKeep,
  input  logic        intMask,
  input  logic        tmrAIrq,
  input  logic        tmrAIrqEn,
  input  logic        extIrq,
  input  logic        extIrqEn,
  input  logic        settleDone,
  input  pdm_mode_e   tgtMode,
  output pdm_mode_e   mode,
  output logic        wakeExc,
  output pdm_strobe_t stb
);

  pdm_mode_e nxt;
  logic      fromRst, fromRstNxt, pulseNxt;
  logic      wakeAny, wakeExt;

  assign wakeExt = !intMask && extIrq && extIrqEn;
  assign wakeAny = wakeExt || (!intMask && tmrAIrq && tmrAIrqEn);

  always_comb begin
    nxt        = mode;
    stb        = '0;
    pulseNxt   = 1'b0;
    fromRstNxt = fromRst;
    case (mode)
      M_HIGH, M_MED: begin
        if (sleepReq && deepStop) nxt = watchKeep ? M_WATCH : M_STBY;
      end
      M_SUB: begin
        if (sleepReq) begin
          if (!deepStop && lowPwrSel && watchKeep) nxt = M_SUBSLP;
          else if (deepStop && watchKeep)          nxt = M_WATCH;
        end
      end
      M_SUBSLP: begin
        if (wakeAny) begin
          nxt      = M_SUB;
          pulseNxt = 1'b1;
        end
      end
      M_WATCH: begin
        if (wakeAny) begin
          if (lowPwrSel) begin
            nxt      = M_SUB;
            pulseNxt = 1'b1;
          end else begin
            nxt           = M_SETTLE;
            stb.clrCnt    = 1'b1;
            stb.latchWake = 1'b1;
            fromRstNxt    = 1'b0;
          end
        end
      end
      M_STBY: begin
        if (wakeExt) begin
          nxt           = M_SETTLE;
          stb.clrCnt    = 1'b1;
          stb.latchWake = 1'b1;
          fromRstNxt    = 1'b0;
        end
      end
      M_SETTLE: begin
        if (settleDone) begin
          nxt      = tgtMode;
          pulseNxt = !fromRst;
        end
      end
      default: nxt = M_HIGH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_SETTLE;
      wakeExc <= 1'b0;
      fromRst <= 1'b1;
    end else begin
      mode    <= nxt;
      wakeExc <= pulseNxt;
      fromRst <= fromRstNxt;
    end
  end

endmodule

// File: rtl/pdm_seq.sv
module pdm_seq
  import pdm_pkg::*;
#(
  parameter int         LONG_LOG2 = 13,
  parameter logic [2:0] RST_SEL   = 3'd7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleepReq,
  input  logic       deepStop,
  input  logic       lowPwrSel,
  input  logic       midSpeedSel,
  input  logic       watchKeep,
  input  logic [2:0] settleSel,
  input  logic       intMask,
  input  logic       tmrAIrq,
  input  logic       tmrAIrqEn,
  input  logic       extIrq,
  input  logic       extIrqEn,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       timerAClkEn,
  output logic       stateHold,
  output logic       wakeExc,
  output logic [2:0] modeCode
);

  pdm_strobe_t stb;
  pdm_mode_e   mode, tgtMode;
  logic        settleDone;

  pdm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .deepStop(deepStop),
    .lowPwrSel(lowPwrSel), .watchKeep(watchKeep), .intMask(intMask),
    .tmrAIrq(tmrAIrq), .tmrAIrqEn(tmrAIrqEn), .extIrq(extIrq),
    .extIrqEn(extIrqEn), .settleDone(settleDone), .tgtMode(tgtMode),
    .mode(mode), .wakeExc(wakeExc), .stb(stb)
  );

  pdm_dp #(.LONG_LOG2(LONG_LOG2), .RST_SEL(RST_SEL)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .settleSel(settleSel),
    .midSpeedSel(midSpeedSel), .tgtMode(tgtMode), .settleDone(settleDone)
  );

  assign cpuClkEn    = mode inside {M_HIGH, M_MED, M_SUB};
  assign periphClkEn = mode inside {M_HIGH, M_MED, M_SUB};
  assign timerAClkEn = mode inside {M_HIGH, M_MED, M_SUB, M_SUBSLP, M_WATCH};
  assign stateHold   = mode inside {M_SUBSLP, M_WATCH, M_STBY, M_SETTLE};
  assign modeCode    = mode;

endmodule

// File: rtl/pdm_seq_chk.sv
module pdm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleepReq,
  input logic       deepStop,
  input logic       lowPwrSel,
  input logic       watchKeep,
  input logic       intMask,
  input logic       tmrAIrq,
  input logic       tmrAIrqEn,
  input logic       extIrq,
  input logic       cpuClkEn,
  input logic       periphClkEn,
  input logic       timerAClkEn,
  input logic       stateHold,
  input logic       wakeExc,
  input logic [2:0] modeCode
);

  p_active_stay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (modeCode <= 3'd1 && !(sleepReq && deepStop)) |=> (modeCode == $past(modeCode)));

  p_subsleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (modeCode == 3'd2 && sleepReq && !deepStop && lowPwrSel && watchKeep) |=> (modeCode == 3'd3));

  p_mask_holds_watch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (modeCode == 3'd4 && intMask) |=> (modeCode == 3'd4));

  p_sub_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (modeCode == 3'd4 && !intMask && tmrAIrq && tmrAIrqEn && lowPwrSel) |=> (modeCode == 3'd2 && wakeExc));

  p_settle_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (modeCode == 3'd6) |-> (!cpuClkEn && !periphClkEn && !timerAClkEn && stateHold));

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wakeExc |=> !wakeExc);

  p_pulse_in_run_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wakeExc |-> (modeCode <= 3'd2));

  p_subsleep_clocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (modeCode == 3'd3) |-> (!cpuClkEn && !periphClkEn && timerAClkEn && stateHold));

  p_stby_needs_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (modeCode == 3'd5 && !extIrq) |=> (modeCode == 3'd5));

endmodule

bind pdm_seq pdm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .deepStop(deepStop),
  .lowPwrSel(lowPwrSel), .watchKeep(watchKeep), .intMask(intMask),
  .tmrAIrq(tmrAIrq), .tmrAIrqEn(tmrAIrqEn), .extIrq(extIrq),
  .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .timerAClkEn(timerAClkEn),
  .stateHold(stateHold), .wakeExc(wakeExc), .modeCode(modeCode)
);

// File: tb/pdm_seq_bench.sv
module pdm_seq_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleepReq = 0, deepStop = 0, lowPwrSel = 0, midSpeedSel = 0, watchKeep = 0;
  logic [2:0] settleSel = 3'd0;
  logic intMask = 0, tmrAIrq = 0, tmrAIrqEn = 0, extIrq = 0, extIrqEn = 0;
  logic cpuClkEn, periphClkEn, timerAClkEn, stateHold, wakeExc;
  logic [2:0] modeCode;

  int nChk = 0;
  int nBad = 0;
  string curReq = "R1";

  // reference model state
  int mMode = 6;
  int mTgt = 0;
  int mLeft = 16;
  bit mFromRst = 1'b1;
  bit mWake = 1'b0;

  always #10 clk = ~clk;

  pdm_seq u_pdm_seq (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .deepStop(deepStop),
    .lowPwrSel(lowPwrSel), .midSpeedSel(midSpeedSel), .watchKeep(watchKeep),
    .settleSel(settleSel), .intMask(intMask), .tmrAIrq(tmrAIrq),
    .tmrAIrqEn(tmrAIrqEn), .extIrq(extIrq), .extIrqEn(extIrqEn),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .timerAClkEn(timerAClkEn),
    .stateHold(stateHold), .wakeExc(wakeExc), .modeCode(modeCode)
  );

  function automatic int settleRef(input int s);
    case (s)
      0: return 8192;
      1: return 16384;
      2: return 32768;
      3: return 65536;
      4: return 131072;
      5: return 2;
      6: return 8;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mMode = 6; mTgt = 0; mLeft = 16; mFromRst = 1'b1; mWake = 1'b0;
    end else begin
      bit wk, wkExt;
      wkExt = !intMask && extIrq && extIrqEn;
      wk    = wkExt || (!intMask && tmrAIrq && tmrAIrqEn);
      mWake = 1'b0;
      if (mMode == 0 || mMode == 1) begin
        if (sleepReq && deepStop) mMode = watchKeep ? 4 : 5;
      end else if (mMode == 2) begin
        if (sleepReq && !deepStop && lowPwrSel && watchKeep) mMode = 3;
        else if (sleepReq && deepStop && watchKeep) mMode = 4;
      end else if (mMode == 3) begin
        if (wk) begin mMode = 2; mWake = 1'b1; end
      end else if (mMode == 4 || mMode == 5) begin
        if ((mMode == 4 && wk && lowPwrSel)) begin
          mMode = 2; mWake = 1'b1;
        end else if ((mMode == 4 && wk) || (mMode == 5 && wkExt)) begin
          mMode = 6; mTgt = midSpeedSel ? 1 : 0;
          mLeft = settleRef(int'(settleSel)); mFromRst = 1'b0;
        end
      end else begin
        if (mLeft == 1) begin mMode = mTgt; mWake = !mFromRst; end
        else mLeft = mLeft - 1;
      end
    end
  end

  // cycle compare against the model
  always @(negedge clk) begin
    logic eRun, eTa, eHold;
    eRun  = (mMode <= 2);
    eTa   = (mMode <= 4);
    eHold = (mMode >= 3);
    nChk++;
    if (modeCode !== mMode[2:0] || cpuClkEn !== eRun || periphClkEn !== eRun ||
        timerAClkEn !== eTa || stateHold !== eHold || wakeExc !== mWake) begin
      nBad++;
      $display("FAIL %s cycle: mode=%0d cpu=%b per=%b ta=%b hold=%b wake=%b exp mode=%0d cpu=%b per=%b ta=%b hold=%b wake=%b",
               curReq, modeCode, cpuClkEn, periphClkEn, timerAClkEn, stateHold, wakeExc,
               mMode, eRun, eRun, eTa, eHold, mWake);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic pulseSleep();
    sleepReq = 1'b1; tick(); sleepReq = 1'b0;
  endtask

  task automatic pulseTa();
    tmrAIrq = 1'b1; tick(); tmrAIrq = 1'b0;
  endtask

  task automatic pulseExt();
    extIrq = 1'b1; tick(); extIrq = 1'b0;
  endtask

  task automatic settleLen(output int n);
    n = 0;
    while (modeCode == 3'd6) begin
      tick();
      n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state then settle into high speed
    curReq = "R1";
    repeat (3) tick();
    chk(modeCode == 3'd6 && stateHold, "R1", modeCode, 6);
    rst_n = 1'b1;
    settleLen(n);
    chk(n == 16, "R1", n, 16);
    chk(modeCode == 3'd0 && !wakeExc, "R1", modeCode, 0);

    // R2: sleep request paths from active
    curReq = "R2";
    deepStop = 0; watchKeep = 1; pulseSleep();
    chk(modeCode == 3'd0, "R2", modeCode, 0);
    deepStop = 1; watchKeep = 0; pulseSleep();
    chk(modeCode == 3'd5, "R2", modeCode, 5);
    curReq = "R8";
    chk(!cpuClkEn && !timerAClkEn && stateHold, "R8", {cpuClkEn, timerAClkEn, stateHold}, 1);

    // R10: standby wake only by external interrupt
    curReq = "R10";
    tmrAIrqEn = 1; pulseTa();
    chk(modeCode == 3'd5, "R10", modeCode, 5);
    intMask = 1; extIrqEn = 1; pulseExt();
    chk(modeCode == 3'd5, "R10", modeCode, 5);
    intMask = 0; midSpeedSel = 1; lowPwrSel = 1; settleSel = 3'd5; pulseExt();
    settleLen(n);
    chk(n == 2, "R6", n, 2);
    chk(modeCode == 3'd1, "R10", modeCode, 1);
    chk(wakeExc == 1'b1, "R7", wakeExc, 1);
    tick();
    chk(wakeExc == 1'b0, "R7", wakeExc, 0);

    // R2/R4: into watch, gated wakes
    curReq = "R2";
    lowPwrSel = 0; deepStop = 1; watchKeep = 1; pulseSleep();
    chk(modeCode == 3'd4, "R2", modeCode, 4);
    curReq = "R4";
    tmrAIrqEn = 0; extIrqEn = 0; pulseTa(); pulseExt();
    chk(modeCode == 3'd4, "R4", modeCode, 4);
    tmrAIrqEn = 1; intMask = 1; pulseTa();
    chk(modeCode == 3'd4, "R4", modeCode, 4);
    intMask = 0;

    // R5: wake to high speed through 8-cycle settle
    curReq = "R5";
    midSpeedSel = 0; settleSel = 3'd6; pulseTa();
    settleLen(n);
    chk(n == 8, "R6", n, 8);
    chk(modeCode == 3'd0, "R5", modeCode, 0);

    // R5: wake straight to subactive
    pulseSleep();
    lowPwrSel = 1; extIrqEn = 1; pulseExt();
    chk(modeCode == 3'd2 && wakeExc, "R5", modeCode, 2);

    // R3: subsleep entry conditions
    curReq = "R3";
    deepStop = 0; lowPwrSel = 0; watchKeep = 1; pulseSleep();
    chk(modeCode == 3'd2, "R3", modeCode, 2);
    lowPwrSel = 1; watchKeep = 0; pulseSleep();
    chk(modeCode == 3'd2, "R3", modeCode, 2);
    deepStop = 1; pulseSleep();
    chk(modeCode == 3'd2, "R3", modeCode, 2);
    deepStop = 0; watchKeep = 1; pulseSleep();
    chk(modeCode == 3'd3, "R3", modeCode, 3);
    curReq = "R8";
    chk(!cpuClkEn && !periphClkEn && timerAClkEn && stateHold, "R8", modeCode, 3);

    // R9: subsleep wake
    curReq = "R9";
    intMask = 1; pulseExt();
    chk(modeCode == 3'd3, "R9", modeCode, 3);
    intMask = 0; pulseTa();
    chk(modeCode == 3'd2 && wakeExc, "R9", modeCode, 2);

    // R6: long settle from subactive via watch
    curReq = "R6";
    deepStop = 1; watchKeep = 1; pulseSleep();
    lowPwrSel = 0; midSpeedSel = 0; settleSel = 3'd0; pulseTa();
    settleLen(n);
    chk(n == 8192, "R6", n, 8192);
    chk(modeCode == 3'd0, "R6", modeCode, 0);
    pulseSleep();
    midSpeedSel = 1; settleSel = 3'd7; pulseTa();
    settleLen(n);
    chk(n == 16, "R6", n, 16);
    chk(modeCode == 3'd1, "R6", modeCode, 1);

    // R1: reset from subsleep uses the reset settle time
    curReq = "R1";
    pulseSleep();
    lowPwrSel = 1; pulseTa();
    deepStop = 0; pulseSleep();
    chk(modeCode == 3'd3, "R1", modeCode, 3);
    settleSel = 3'd5;
    rst_n = 1'b0; tick();
    chk(modeCode == 3'd6 && stateHold && !cpuClkEn, "R1", modeCode, 6);
    tick(); tick();
    rst_n = 1'b1;
    settleLen(n);
    chk(n == 16, "R1", n, 16);
    chk(modeCode == 3'd0 && !wakeExc, "R7", wakeExc, 0);
    tick();

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule